// File: doc/BRIEF.md
# Supply Protection and Soft-Start Sequencer

This block decides whether the deflection drive stages of a display controller may run. It watches two digital supply comparators, one tripping near 8.3 V and one tripping near 8.1 V. It also holds a soft-start bit that the host loads over the serial control bus. A supply below the upper threshold keeps the block in standby. In standby the register bank is held cleared and the bus slave is told not to acknowledge. Once the supply is above the upper threshold, writes are acknowledged and accepted. The drive, vertical and lock-status outputs stay off until the soft-start bit reads one.

During operation the supply may fall below the lower threshold. The block then latches into a protection state. In that state the drive outputs go off and the lock/status pin is released to high impedance, so a host can sense the fault. The block leaves protection only once the supply has risen above the upper threshold again. It then goes through standby, and standby clears the soft-start bit. Both comparator inputs are synchronized and debounced for a programmable number of cycles before the state machine uses them.

Top module: `supply_prot_seq`

## Requirements
- R1: After reset the block is in standby: outEnable=0, ackEnable=0, regReset=1, statusDrive=0 (status pin floating).
- R2: While the debounced upper comparator (supplyAboveHigh, 1 = supply above threshold) is low, the block stays in standby with regReset=1 and ackEnable=0, whatever supplyAboveLow does.
- R3: With both debounced comparators high, the block leaves standby: ackEnable=1 and regReset=0. An accepted write with cfgWrData bit SOFT_BIT (default bit 0) set to 1 then leads to outEnable=1 and statusDrive=1.
- R4: outEnable and statusDrive are 1 only while the soft-start bit is 1. While it is 0 and the supply is good, the outputs are outEnable=0, ackEnable=1, regReset=0, statusDrive=0.
- R5: An accepted write with bit SOFT_BIT equal to 0 while the outputs are enabled turns outEnable and statusDrive off. ackEnable stays 1.
- R6: When only the upper comparator falls while the outputs are enabled, the outputs stay enabled.
- R7: When the debounced lower comparator (supplyAboveLow) falls while the bus is enabled, the block enters protection: outEnable=0, ackEnable=0, regReset=0, statusDrive=0.
- R8: Writes are ignored while ackEnable=0. A soft-start write made in standby or in protection does not enable the outputs once the bus becomes enabled.
- R9: Protection is kept while the upper comparator stays low, even after the lower comparator recovers. Once the upper comparator is high, the block passes through standby. The soft-start bit is cleared on that path, so it ends with ackEnable=1 and outEnable=0.
- R10: A comparator change that lasts fewer than DEB_CYCLES cycles has no effect. A change held for more than DEB_CYCLES+2 cycles takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| supplyAboveHigh | input | 1 | Upper supply comparator, 1 = above about 8.3 V |
| supplyAboveLow | input | 1 | Lower supply comparator, 1 = above about 8.1 V |
| cfgWrStb | input | 1 | One-cycle register write strobe from the bus slave |
| cfgWrData | input | DATA_W | Write data; bit SOFT_BIT is the soft-start bit |
| outEnable | output | 1 | Enable for the horizontal drive, B+ drive and vertical stages |
| ackEnable | output | 1 | Lets the bus slave acknowledge |
| regReset | output | 1 | Holds the control register bank in reset |
| statusDrive | output | 1 | 1 drives the lock/status pin, 0 floats it |

## Verification
The assertions assume the comparator inputs are consistent: when supplyAboveHigh is high for a long stretch, supplyAboveLow is high too. They also assume the write strobe lasts one cycle with data that is stable while it is high. The stimulus keeps the comparators consistent at every point where the block is expected to act on them. Comparator changes are made at the falling edge and held for well over the debounce window. The one exception is the deliberate short glitch. Writes are single-cycle strobes launched between clock edges.

// File: rtl/supply_prot_pkg.sv
package supply_prot_pkg;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_WAIT    = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_PROTECT = 2'd3
  } protState_t;

  typedef struct packed {
    logic clearSoft;
    logic acceptWr;
    logic enDrive;
    logic enAck;
    logic enStatus;
  } protStrobe_t;

  localparam int CMP_LOW  = 0;
  localparam int CMP_HIGH = 1;
  localparam int NUM_CMP  = 2;

endpackage

// File: rtl/prot_debounce.sv
module prot_debounce #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] cnt;
  logic          filtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      cnt   <= '0;
      filtQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == filtQ) begin
        cnt <= '0;
      end else if (cnt == CW'(DEB_CYCLES - 1)) begin
        filtQ <= syncQ[1];
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign filtOut = filtQ;

  // R10: the filtered level only moves toward the synchronized level
  assert_filter_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    (filtQ != $past(filtQ)) |-> ($past(syncQ[1]) == filtQ));

  // R10: the run counter never passes the debounce window
  assert_count_bounded_R10: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(DEB_CYCLES - 1));

endmodule

// File: rtl/prot_datapath.sv
module prot_datapath
  import supply_prot_pkg::*;
#(
  parameter int DEB_CYCLES = 16,
  parameter int DATA_W     = 8,
  parameter int SOFT_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawHigh,
  input  logic              rawLow,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  protStrobe_t       strobes,
  output logic              highOk,
  output logic              lowOk,
  output logic              softBit,
  output logic              softNext
);
  logic [NUM_CMP-1:0] rawVec;
  logic [NUM_CMP-1:0] filtVec;
  logic               softQ;

  assign rawVec[CMP_LOW]  = rawLow;
  assign rawVec[CMP_HIGH] = rawHigh;

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    prot_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawVec[gi]),
      .filtOut (filtVec[gi])
    );
  end

  assign highOk = filtVec[CMP_HIGH];
  assign lowOk  = filtVec[CMP_LOW];

  always_comb begin
    softNext = softQ;
    if (strobes.clearSoft) begin
      softNext = 1'b0;
    end else if (strobes.acceptWr && wrStb) begin
      softNext = wrData[SOFT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) softQ <= 1'b0;
    else       softQ <= softNext;
  end

  assign softBit = softQ;

  // R2: a standby cycle leaves the soft-start bit cleared
  assert_standby_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearSoft |=> !softQ);

  // R8: without bus acceptance the soft-start bit cannot change
  assert_no_ack_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.acceptWr && !strobes.clearSoft) |=> $stable(softQ));

endmodule

// File: rtl/prot_control.sv
module prot_control
  import supply_prot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        highOk,
  input  logic        lowOk,
  input  logic        softBit,
  input  logic        softNext,
  output protStrobe_t strobes
);
  protState_t stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_STANDBY: if (highOk && lowOk) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (!lowOk)        stateNext = ST_PROTECT;
        else if (softNext) stateNext = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (!lowOk)         stateNext = ST_PROTECT;
        else if (!softNext) stateNext = ST_WAIT;
      end
      ST_PROTECT: if (highOk) stateNext = ST_STANDBY;
      default: stateNext = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_STANDBY;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strobes           = '0;
    strobes.clearSoft = (stateQ == ST_STANDBY);
    strobes.acceptWr  = (stateQ == ST_WAIT) || (stateQ == ST_ACTIVE);
    strobes.enAck     = strobes.acceptWr;
    strobes.enDrive   = (stateQ == ST_ACTIVE);
    strobes.enStatus  = (stateQ == ST_ACTIVE);
  end

  // R4: outputs only run with the soft-start bit set
  assert_drive_needs_soft_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.enDrive || strobes.enStatus) |-> softBit);

  // R7: a low lower-comparator shuts everything off on the next cycle
  assert_low_trip_R7: assert property (@(posedge clk) disable iff (!rstN)
    !lowOk |=> (!strobes.enDrive && !strobes.enStatus && !strobes.enAck));

  // R9: protection exits only toward standby
  assert_protect_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PROTECT) |=> (stateQ == ST_PROTECT || stateQ == ST_STANDBY));

  // R6: the upper comparator alone never stops an active stage
  assert_hold_active_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACTIVE && lowOk && softNext) |=> (stateQ == ST_ACTIVE));

  // R2: standby is left only with a good upper comparator
  assert_standby_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STANDBY && !highOk) |=> (stateQ == ST_STANDBY));

endmodule

// File: rtl/supply_prot_seq.sv
module supply_prot_seq
  import supply_prot_pkg::*;
#(
  parameter int DEB_CYCLES = 16,
  parameter int DATA_W     = 8,
  parameter int SOFT_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyAboveHigh,
  input  logic              supplyAboveLow,
  input  logic              cfgWrStb,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic              outEnable,
  output logic              ackEnable,
  output logic              regReset,
  output logic              statusDrive
);
  protStrobe_t strobes;
  logic highOk, lowOk, softBit, softNext;

  prot_datapath #(
    .DEB_CYCLES (DEB_CYCLES),
    .DATA_W     (DATA_W),
    .SOFT_BIT   (SOFT_BIT)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .rawHigh  (supplyAboveHigh),
    .rawLow   (supplyAboveLow),
    .wrStb    (cfgWrStb),
    .wrData   (cfgWrData),
    .strobes  (strobes),
    .highOk   (highOk),
    .lowOk    (lowOk),
    .softBit  (softBit),
    .softNext (softNext)
  );

  prot_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .highOk   (highOk),
    .lowOk    (lowOk),
    .softBit  (softBit),
    .softNext (softNext),
    .strobes  (strobes)
  );

  assign outEnable   = strobes.enDrive;
  assign ackEnable   = strobes.enAck;
  assign regReset    = strobes.clearSoft;
  assign statusDrive = strobes.enStatus;

endmodule

// File: tb/supply_prot_seq_tb.sv
module supply_prot_seq_tb;
  localparam int DEB    = 16;
  localparam int DATA_W = 8;
  localparam int SETTLE = DEB + 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hiIn = 1'b0;
  logic loIn = 1'b0;
  logic wrStb = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic outEnable, ackEnable, regReset, statusDrive;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  drv;
    logic  ack;
    logic  clr;
    logic  oe;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  supply_prot_seq #(.DEB_CYCLES(DEB), .DATA_W(DATA_W), .SOFT_BIT(0)) u_dut (
    .clk             (clk),
    .rstN            (rstN),
    .supplyAboveHigh (hiIn),
    .supplyAboveLow  (loIn),
    .cfgWrStb        (wrStb),
    .cfgWrData       (wrData),
    .outEnable       (outEnable),
    .ackEnable       (ackEnable),
    .regReset        (regReset),
    .statusDrive     (statusDrive)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      total++;
      if ({outEnable, ackEnable, regReset, statusDrive} !== {e.drv, e.ack, e.clr, e.oe}) begin
        bad++;
        $display("FAIL %s: got drv/ack/clr/oe=%b%b%b%b expected %b%b%b%b", e.req,
                 outEnable, ackEnable, regReset, statusDrive, e.drv, e.ack, e.clr, e.oe);
      end
    end
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic expectOut(input logic d, input logic a, input logic c, input logic o,
                           input string req);
    expItem_t e;
    @(posedge clk);
    #2;
    e.drv = d; e.ack = a; e.clr = c; e.oe = o; e.req = req;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrStb  = 1'b1;
    wrData = d;
    @(negedge clk);
    wrStb  = 1'b0;
    wrData = '0;
    waitCyc(3);
  endtask

  task automatic setSupply(input logic h, input logic l);
    @(negedge clk);
    hiIn = h;
    loIn = l;
    waitCyc(SETTLE);
  endtask

  initial begin
    waitCyc(4);
    @(negedge clk);
    rstN = 1'b1;
    expectOut(0, 0, 1, 0, "R1 reset state");

    // R8: write in standby is ignored
    busWrite(8'h01);
    expectOut(0, 0, 1, 0, "R8 standby write no ack");
    // R2: lower comparator alone keeps standby
    setSupply(1'b0, 1'b1);
    expectOut(0, 0, 1, 0, "R2 upper low holds standby");
    setSupply(1'b1, 1'b1);
    expectOut(0, 1, 0, 0, "R3 supply good leaves standby");
    expectOut(0, 1, 0, 0, "R8 earlier standby write ignored");

    busWrite(8'hFE);
    expectOut(0, 1, 0, 0, "R4 soft bit zero keeps outputs off");
    busWrite(8'h01);
    expectOut(1, 1, 0, 1, "R3 soft start enables outputs");
    busWrite(8'h00);
    expectOut(0, 1, 0, 0, "R5 soft bit cleared disables outputs");
    busWrite(8'h01);
    expectOut(1, 1, 0, 1, "R3 re-enable");

    // R10: short glitch on the lower comparator
    @(negedge clk);
    loIn = 1'b0;
    waitCyc(DEB - 4);
    @(negedge clk);
    loIn = 1'b1;
    waitCyc(SETTLE);
    expectOut(1, 1, 0, 1, "R10 short glitch ignored");

    setSupply(1'b0, 1'b1);
    expectOut(1, 1, 0, 1, "R6 hysteresis keeps active");
    setSupply(1'b0, 1'b0);
    expectOut(0, 0, 0, 0, "R7 lower trip enters protection");
    expectOut(0, 0, 0, 0, "R10 held change takes effect");

    setSupply(1'b0, 1'b1);
    expectOut(0, 0, 0, 0, "R9 lower recovery alone keeps protection");
    busWrite(8'h01);
    expectOut(0, 0, 0, 0, "R8 protection write ignored");
    setSupply(1'b1, 1'b1);
    expectOut(0, 1, 0, 0, "R9 exit through standby clears soft bit");

    busWrite(8'h01);
    expectOut(1, 1, 0, 1, "R3 active again");
    setSupply(1'b0, 1'b0);
    expectOut(0, 0, 0, 0, "R7 full drop enters protection");
    waitCyc(50);
    expectOut(0, 0, 0, 0, "R9 protection latched");

    waitCyc(2);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule